// File: doc/BRIEF.md
# Pairwise Vote Tally for a Ten-Class Decision

This block turns the outcomes of all two-class contests among ten classes into one class prediction. Each of the 45 contests settles one unordered pair of classes and yields a single bit. The block converts every bit into one vote for one class of its pair. It keeps a vote counter for each class and, once every contest of an image is in, reports the class with the highest count.

Contest bits can arrive in two ways. The first is one per cycle, each tagged with its pair index. This suits an upstream engine that settles the contests one after another over many cycles. The second is all 45 at once as a vector. A start strobe opens a new image. The live counters are visible at all times. A one-cycle valid pulse marks each new prediction, and the prediction then holds until the next one.

Top module: `pairwise_vote_tally`

## Requirements
- R1: Pair index p names the p-th pair (a, b) with a < b, counted with a as the slower key and b as the faster key, both ascending: index 0 is 0v1, index 8 is 0v9, index 9 is 1v2 and index 44 is 8v9. A serial bit of 1 adds one vote to class a and a bit of 0 adds one vote to class b. The new count shows on the vote outputs after the next clock edge.
- R2: A start strobe clears every counter and the error flag at the next edge. A serial decision presented in the same cycle as the start is counted as the first decision of the new image.
- R3: A vector load sets every counter to the tally of the 45 bits, replacing all prior counts. Bit p of the vector is the contest with pair index p and follows the R1 vote rule. The counts then sum to 45.
- R4: The valid pulse is high for exactly one cycle. It comes two edges after the 45th accepted decision of an image is presented, and two edges after a vector load.
- R5: The reported class is the class with the highest count. If several classes share that count, the lowest-numbered of them is reported.
- R6: A serial decision whose pair index is 45 or above changes no counter and is not counted toward the 45. It sets the error flag, which stays set until a start.
- R7: A counter that has reached 15 stays at 15 when more votes arrive for its class.
- R8: Out of reset all counters are zero, and the class output, the valid pulse and the error flag are zero. The class output keeps its last value between valid pulses.
- R9: When a vector load and a serial decision arrive in the same cycle, the vector wins and the serial decision is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Opens a new image: clears counters and the error flag |
| dec_valid_i | input | 1 | A serial contest bit is present |
| dec_pair_i | input | 6 | Pair index of the serial bit |
| dec_vote_i | input | 1 | Serial bit: 1 votes for the lower class, 0 for the higher |
| vec_valid_i | input | 1 | Load all 45 contest bits at once |
| vec_dec_i | input | 45 | Contest bits, bit p belonging to pair index p |
| class_o | output | 4 | Predicted class |
| result_valid_o | output | 1 | One-cycle pulse marking a new prediction |
| votes_o | output | 40 | Live counters, class c in bits 4c+3 down to 4c |
| pair_err_o | output | 1 | Sticky flag for an out-of-range pair index |

## Verification
The counters are registers, so a vote or a vector load shows on the vote outputs one edge after it is presented. The valid pulse and the class come from a second register stage and show one edge later than the counts. The bench drives inputs on falling edges. It reads the counts at the first falling edge after the stimulus and the class and valid at the second. It also confirms that valid is low at the first sample and low again at the third. Ignored decisions and dropped serial bits are confirmed by reading the counters at the sample point where a change would have shown.

// File: rtl/pv_pkg.sv
// Package: pair enumeration helpers shared by the voting block.
// Assumes classes are numbered from 0 and pairs are enumerated with the
// lower class as the slow key.
package pv_pkg;

    // Number of unordered pairs among n classes.
    function automatic int pair_count(input int n);
        return (n * (n - 1)) / 2;
    endfunction

    // Lower class of pair index p.
    function automatic int pair_lo(input int n, input int p);
        int k;
        int r;
        k = 0;
        r = 0;
        for (int a = 0; a < n - 1; a++) begin
            for (int b = a + 1; b < n; b++) begin
                if (k == p) r = a;
                k++;
            end
        end
        return r;
    endfunction

    // Higher class of pair index p.
    function automatic int pair_hi(input int n, input int p);
        int k;
        int r;
        k = 0;
        r = 1;
        for (int a = 0; a < n - 1; a++) begin
            for (int b = a + 1; b < n; b++) begin
                if (k == p) r = b;
                k++;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pv_pair_decode.sv
// Module: pv_pair_decode
// Turns one serial contest bit and its pair index into a one-hot vote.
// Assumes at most one decision per cycle; indices at or above NP are invalid.
module pv_pair_decode #(
    parameter int N_CLS = 10,
    parameter int NP    = 45,
    parameter int PIX_W = 6
) (
    input  logic             valid_i,
    input  logic [PIX_W-1:0] pair_i,
    input  logic             vote_i,
    output logic [N_CLS-1:0] vote_o,
    output logic             ok_o,
    output logic             bad_o
);

    logic [NP-1:0]             hit;
    logic [NP-1:0][N_CLS-1:0]  cand;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        localparam int LO = pv_pkg::pair_lo(N_CLS, p);
        localparam int HI = pv_pkg::pair_hi(N_CLS, p);
        localparam logic [N_CLS-1:0] LO_MASK = N_CLS'(1) << LO;
        localparam logic [N_CLS-1:0] HI_MASK = N_CLS'(1) << HI;
        assign hit[p]  = (pair_i == PIX_W'(p));
        assign cand[p] = hit[p] ? (vote_i ? LO_MASK : HI_MASK) : '0;
    end

    // Merge the per-pair candidates into one vote and classify the index.
    always_comb begin
        vote_o = '0;
        for (int p = 0; p < NP; p++) vote_o = vote_o | cand[p];
        ok_o  = valid_i && (|hit);
        bad_o = valid_i && !(|hit);
    end

endmodule

// File: rtl/pv_vector_tally.sv
// Module: pv_vector_tally
// Counts the votes every class receives from a full vector of contest bits.
// Assumes counts fit CNT_W bits (at most N_CLS-1 votes per class).
module pv_vector_tally #(
    parameter int N_CLS = 10,
    parameter int NP    = 45,
    parameter int CNT_W = 4
) (
    input  logic [NP-1:0]                  vec_i,
    output logic [N_CLS-1:0][CNT_W-1:0]    cnt_o
);

    logic [NP-1:0][N_CLS-1:0] cand;

    for (genvar p = 0; p < NP; p++) begin : g_pair
        localparam int LO = pv_pkg::pair_lo(N_CLS, p);
        localparam int HI = pv_pkg::pair_hi(N_CLS, p);
        localparam logic [N_CLS-1:0] LO_MASK = N_CLS'(1) << LO;
        localparam logic [N_CLS-1:0] HI_MASK = N_CLS'(1) << HI;
        assign cand[p] = vec_i[p] ? LO_MASK : HI_MASK;
    end

    // Sum each class column over all pairs.
    always_comb begin
        cnt_o = '0;
        for (int c = 0; c < N_CLS; c++) begin
            for (int p = 0; p < NP; p++) begin
                cnt_o[c] = cnt_o[c] + CNT_W'(cand[p][c]);
            end
        end
    end

endmodule

// File: rtl/pv_count_bank.sv
// Module: pv_count_bank
// One saturating vote counter per class with clear, bulk load and increment.
// Assumes load has priority over clear and increment.
module pv_count_bank #(
    parameter int N_CLS = 10,
    parameter int CNT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear_i,
    input  logic                         load_i,
    input  logic [N_CLS-1:0][CNT_W-1:0]  load_cnt_i,
    input  logic [N_CLS-1:0]             inc_i,
    output logic [N_CLS-1:0][CNT_W-1:0]  cnt_o
);

    for (genvar c = 0; c < N_CLS; c++) begin : g_cls
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] base;

        assign base     = clear_i ? '0 : cnt_q;
        assign cnt_o[c] = cnt_q;

        // Counter update: load, else clear-and-add with saturation.
        always_ff @(posedge clk) begin
            if (!rst_n)                        cnt_q <= '0;
            else if (load_i)                   cnt_q <= load_cnt_i[c];
            else if (inc_i[c] && base != '1)   cnt_q <= base + 1'b1;
            else                               cnt_q <= base;
        end
    end

endmodule

// File: rtl/pv_argmax_select.sv
// Module: pv_argmax_select
// Registers the index of the largest count; the lowest index wins ties.
// Assumes go_i is high only in cycles where cnt_i holds a complete image.
module pv_argmax_select #(
    parameter int N_CLS = 10,
    parameter int CNT_W = 4,
    parameter int CLS_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         go_i,
    input  logic [N_CLS-1:0][CNT_W-1:0]  cnt_i,
    output logic [CLS_W-1:0]             cls_o,
    output logic                         valid_o
);

    logic [CLS_W-1:0] best;
    logic [CNT_W-1:0] best_cnt;

    // Scan upward; only a strictly larger count displaces the leader.
    always_comb begin
        best     = '0;
        best_cnt = cnt_i[0];
        for (int c = 1; c < N_CLS; c++) begin
            if (cnt_i[c] > best_cnt) begin
                best     = CLS_W'(c);
                best_cnt = cnt_i[c];
            end
        end
    end

    // Capture the winner on request and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= go_i;
            if (go_i) cls_o <= best;
        end
    end

endmodule

// File: rtl/pairwise_vote_tally.sv
// Module: pairwise_vote_tally (top)
// Collects one-vs-one contest bits, serially or as a vector, into per-class
// vote counters and reports the plurality class once all pairs are in.
// Assumes the upstream sends each pair once per image after a start.
module pairwise_vote_tally #(
    parameter  int N_CLS = 10,
    localparam int NP    = pv_pkg::pair_count(N_CLS),
    localparam int PIX_W = $clog2(NP),
    localparam int CNT_W = $clog2(N_CLS),
    localparam int CLS_W = $clog2(N_CLS)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic                     dec_valid_i,
    input  logic [PIX_W-1:0]         dec_pair_i,
    input  logic                     dec_vote_i,
    input  logic                     vec_valid_i,
    input  logic [NP-1:0]            vec_dec_i,
    output logic [CLS_W-1:0]         class_o,
    output logic                     result_valid_o,
    output logic [N_CLS*CNT_W-1:0]   votes_o,
    output logic                     pair_err_o
);

    logic [N_CLS-1:0]             ser_vote;
    logic                         ser_ok;
    logic                         ser_bad;
    logic [N_CLS-1:0]             inc;
    logic                         take;
    logic [N_CLS-1:0][CNT_W-1:0]  vec_cnt;
    logic [N_CLS-1:0][CNT_W-1:0]  cnt;
    logic [PIX_W-1:0]             seen_q;
    logic [PIX_W-1:0]             seen_base;
    logic                         full_q;
    logic                         err_q;

    pv_pair_decode #(.N_CLS(N_CLS), .NP(NP), .PIX_W(PIX_W)) u_dec (
        .valid_i (dec_valid_i),
        .pair_i  (dec_pair_i),
        .vote_i  (dec_vote_i),
        .vote_o  (ser_vote),
        .ok_o    (ser_ok),
        .bad_o   (ser_bad)
    );

    pv_vector_tally #(.N_CLS(N_CLS), .NP(NP), .CNT_W(CNT_W)) u_vec (
        .vec_i (vec_dec_i),
        .cnt_o (vec_cnt)
    );

    // A vector load overrides any serial decision in the same cycle.
    assign take = ser_ok && !vec_valid_i;
    assign inc  = take ? ser_vote : '0;

    pv_count_bank #(.N_CLS(N_CLS), .CNT_W(CNT_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (start_i),
        .load_i     (vec_valid_i),
        .load_cnt_i (vec_cnt),
        .inc_i      (inc),
        .cnt_o      (cnt)
    );

    assign seen_base = start_i ? '0 : seen_q;

    // Accepted-decision count; flags the image complete on the last pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            full_q <= 1'b0;
        end else if (vec_valid_i) begin
            seen_q <= PIX_W'(NP);
            full_q <= 1'b1;
        end else begin
            full_q <= take && (seen_base == PIX_W'(NP - 1));
            if (take && seen_base != '1) seen_q <= seen_base + 1'b1;
            else                         seen_q <= seen_base;
        end
    end

    // Sticky error for invalid indices, cleared by start.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= (start_i ? 1'b0 : err_q) | (ser_bad && !vec_valid_i);
    end

    pv_argmax_select #(.N_CLS(N_CLS), .CNT_W(CNT_W), .CLS_W(CLS_W)) u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (full_q),
        .cnt_i   (cnt),
        .cls_o   (class_o),
        .valid_o (result_valid_o)
    );

    assign votes_o    = cnt;
    assign pair_err_o = err_q;

endmodule

// File: rtl/pv_vote_checker.sv
// Module: pv_vote_checker
// Port-level properties of pairwise_vote_tally, attached with bind.
module pv_vote_checker #(
    parameter  int N_CLS = 10,
    localparam int NP    = pv_pkg::pair_count(N_CLS),
    localparam int PIX_W = $clog2(NP),
    localparam int CNT_W = $clog2(N_CLS),
    localparam int CLS_W = $clog2(N_CLS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start_i,
    input logic                     dec_valid_i,
    input logic [PIX_W-1:0]         dec_pair_i,
    input logic                     vec_valid_i,
    input logic [CLS_W-1:0]         class_o,
    input logic                     result_valid_o,
    input logic [N_CLS*CNT_W-1:0]   votes_o,
    input logic                     pair_err_o
);

    logic [N_CLS*CNT_W-1:0] prev_votes;
    int                     vote_sum;
    logic                   any_full;
    logic                   win_ok;

    // Keep the counts of the previous cycle for the winner check.
    always_ff @(posedge clk) begin
        prev_votes <= votes_o;
    end

    // Derived views of the counters.
    always_comb begin
        vote_sum = 0;
        any_full = 1'b0;
        win_ok   = (int'(class_o) < N_CLS);
        for (int c = 0; c < N_CLS; c++) begin
            vote_sum = vote_sum + int'(votes_o[c*CNT_W +: CNT_W]);
            if (votes_o[c*CNT_W +: CNT_W] == '1) any_full = 1'b1;
            if (int'(class_o) < N_CLS) begin
                if (prev_votes[c*CNT_W +: CNT_W] > prev_votes[int'(class_o)*CNT_W +: CNT_W])
                    win_ok = 1'b0;
                if (c < int'(class_o) &&
                    prev_votes[c*CNT_W +: CNT_W] == prev_votes[int'(class_o)*CNT_W +: CNT_W])
                    win_ok = 1'b0;
            end
        end
    end

    a_r1_one_vote: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i && (int'(dec_pair_i) < NP) && !vec_valid_i && !start_i && !any_full
        |=> vote_sum == $past(vote_sum) + 1);

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !dec_valid_i && !vec_valid_i |=> (votes_o == '0) && !pair_err_o);

    a_r3_vector_sum: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_i |=> vote_sum == NP);

    a_r4_valid_after_vector: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_i |=> ##1 result_valid_o);

    a_r5_plurality_winner: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid_o |-> win_ok);

    a_r6_bad_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid_i && (int'(dec_pair_i) >= NP) && !vec_valid_i && !start_i
        |=> $stable(votes_o) && pair_err_o);

endmodule

bind pairwise_vote_tally pv_vote_checker #(.N_CLS(N_CLS)) u_chk (.*);

// File: tb/sim_pairwise_vote_tally.sv
module sim_pairwise_vote_tally;

    localparam int CLK_PERIOD = 10;
    localparam int NC = 10;
    localparam int NP = 45;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        dec_valid_i = 1'b0;
    logic [5:0]  dec_pair_i = '0;
    logic        dec_vote_i = 1'b0;
    logic        vec_valid_i = 1'b0;
    logic [44:0] vec_dec_i = '0;
    logic [3:0]  class_o;
    logic        result_valid_o;
    logic [39:0] votes_o;
    logic        pair_err_o;

    int nchk  = 0;
    int nfail = 0;
    int mcnt [NC];
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pairwise_vote_tally u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .dec_valid_i(dec_valid_i), .dec_pair_i(dec_pair_i), .dec_vote_i(dec_vote_i),
        .vec_valid_i(vec_valid_i), .vec_dec_i(vec_dec_i),
        .class_o(class_o), .result_valid_o(result_valid_o),
        .votes_o(votes_o), .pair_err_o(pair_err_o)
    );

    function automatic int lo_of(input int p);
        int k = 0;
        int r = 0;
        for (int a = 0; a < NC - 1; a++)
            for (int b = a + 1; b < NC; b++) begin
                if (k == p) r = a;
                k++;
            end
        return r;
    endfunction

    function automatic int hi_of(input int p);
        int k = 0;
        int r = 0;
        for (int a = 0; a < NC - 1; a++)
            for (int b = a + 1; b < NC; b++) begin
                if (k == p) r = b;
                k++;
            end
        return r;
    endfunction

    function automatic longint exp_votes();
        longint r = 0;
        for (int c = 0; c < NC; c++) r = r | (longint'(mcnt[c]) << (4 * c));
        return r;
    endfunction

    function automatic int exp_class();
        int b = 0;
        for (int c = 1; c < NC; c++) if (mcnt[c] > mcnt[b]) b = c;
        return b;
    endfunction

    function automatic bit tops_tie();
        int b = exp_class();
        int n = 0;
        for (int c = 0; c < NC; c++) if (mcnt[c] == mcnt[b]) n++;
        return n > 1;
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < NC; c++) mcnt[c] = 0;
    endtask

    task automatic model_vec(input logic [44:0] v);
        model_clear();
        for (int p = 0; p < NP; p++) begin
            if (v[p]) mcnt[lo_of(p)]++;
            else      mcnt[hi_of(p)]++;
        end
    endtask

    task automatic model_dec(input int p, input bit b);
        int w;
        if (p < NP) begin
            w = b ? lo_of(p) : hi_of(p);
            if (mcnt[w] < 15) mcnt[w]++;
        end
    endtask

    // One serial decision, optionally with start; returns after the edge.
    task automatic send(input int p, input bit b, input bit st);
        @(negedge clk);
        dec_valid_i = 1'b1; dec_pair_i = 6'(p); dec_vote_i = b; start_i = st;
        @(negedge clk);
        dec_valid_i = 1'b0; start_i = 1'b0;
        if (st) model_clear();
        model_dec(p, b);
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        model_clear();
    endtask

    // Vector load, optionally with a competing serial bit; checks timing.
    task automatic send_vec(input logic [44:0] v, input bit with_ser, input string req);
        @(negedge clk);
        vec_valid_i = 1'b1; vec_dec_i = v;
        if (with_ser) begin dec_valid_i = 1'b1; dec_pair_i = 6'd0; dec_vote_i = 1'b1; end
        @(negedge clk);
        vec_valid_i = 1'b0; dec_valid_i = 1'b0;
        model_vec(v);
        chk(req, "counts after load", longint'(votes_o), exp_votes());
        chk("R4", "valid low one edge after load", longint'(result_valid_o), 0);
        @(negedge clk);
        chk("R4", "valid two edges after load", longint'(result_valid_o), 1);
        chk("R5", "class after load", longint'(class_o), longint'(exp_class()));
        @(negedge clk);
        chk("R4", "valid is one cycle", longint'(result_valid_o), 0);
        chk("R8", "class held", longint'(class_o), longint'(exp_class()));
    endtask

    // Full serial image in a rotated order with random bits and stray bad indices.
    task automatic serial_image(input int rot, input bit bad_in);
        for (int k = 0; k < NP; k++) begin
            int p = (k + rot) % NP;
            if (bad_in && k == 20) send(NP + int'($urandom_range(0, 18)), 1'b1, 1'b0);
            send(p, 1'($urandom), k == 0);
        end
        chk("R1", "counts after serial image", longint'(votes_o), exp_votes());
        chk("R4", "valid low after last count", longint'(result_valid_o), 0);
        @(negedge clk);
        chk("R4", "valid after serial image", longint'(result_valid_o), 1);
        chk("R5", "class after serial image", longint'(class_o), longint'(exp_class()));
        chk("R6", "error flag", longint'(pair_err_o), longint'(bad_in));
        @(negedge clk);
        chk("R4", "valid is one cycle", longint'(result_valid_o), 0);
    endtask

    initial begin
        void'($urandom(32'd2718));
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset votes", longint'(votes_o), 0);
        chk("R8", "reset class", longint'(class_o), 0);
        chk("R8", "reset valid", longint'(result_valid_o), 0);
        chk("R8", "reset error", longint'(pair_err_o), 0);

        // R3/R5: all ones gives class c nine-minus-c votes; all zeros gives c votes.
        send_vec('1, 1'b0, "R3");
        chk("R5", "all-ones winner", longint'(class_o), 0);
        send_vec('0, 1'b0, "R3");
        chk("R5", "all-zeros winner", longint'(class_o), 9);

        // R2: start clears a loaded image.
        pulse_start();
        chk("R2", "start clears", longint'(votes_o), 0);

        // R1: pair index mapping.
        send(9, 1'b1, 1'b0);
        chk("R1", "index 9 votes for class 1", longint'(votes_o), longint'(40'h10));
        send(44, 1'b0, 1'b0);
        chk("R1", "index 44 bit 0 votes class 9", longint'(votes_o), exp_votes());
        send(44, 1'b1, 1'b0);
        chk("R1", "index 44 bit 1 votes class 8", longint'(votes_o), exp_votes());
        send(8, 1'b0, 1'b0);
        chk("R1", "index 8 bit 0 votes class 9", longint'(votes_o[39:36]), 2);

        // R6: out-of-range index ignored, sticky flag.
        send(50, 1'b1, 1'b0);
        chk("R6", "bad index leaves counts", longint'(votes_o), exp_votes());
        chk("R6", "bad index sets flag", longint'(pair_err_o), 1);
        send(3, 1'b1, 1'b0);
        chk("R6", "flag sticky", longint'(pair_err_o), 1);
        pulse_start();
        chk("R2", "start clears flag", longint'(pair_err_o), 0);

        // R2: start together with a decision keeps that decision.
        send(0, 1'b0, 1'b1);
        chk("R2", "same-cycle decision counted", longint'(votes_o), longint'(40'h10));

        // R7: saturation.
        pulse_start();
        for (int i = 0; i < 20; i++) send(0, 1'b1, 1'b0);
        chk("R7", "counter saturates", longint'(votes_o), longint'(40'hF));

        // R9: vector wins over a serial bit in the same cycle.
        send_vec(45'h0F0F_0F0F_0F0F, 1'b1, "R9");

        // R5: a vector whose top count is shared.
        begin
            logic [44:0] v = '0;
            for (int t = 0; t < 2000; t++) begin
                v = {$urandom, $urandom};
                model_vec(v);
                if (tops_tie()) break;
            end
            chk("R5", "tie vector found", longint'(tops_tie()), 1);
            send_vec(v, 1'b0, "R5");
        end

        // Random images.
        for (int i = 0; i < 30; i++) send_vec({$urandom, $urandom}, 1'($urandom), "R3");
        for (int i = 0; i < 30; i++) serial_image(int'($urandom_range(0, NP - 1)), (i % 4) == 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule